// File: doc/BRIEF.md
# Command Queue Instruction Executor

This block runs a stream of 64-bit command words, one at a time. Each word comes in on a valid/ready handshake from a local command buffer. The block acts on the word through a register-bus master, or by watching a 16-line trigger event bus. Fetching the words from memory, managing pointers and the registers it targets all sit outside the block.

There are five kinds of command:
- **null** does nothing.
- **write** performs one masked register write.
- **wait** holds execution until one chosen trigger line is high.
- **poll-equal** reads a register again and again until the masked read data equals a target.
- **poll-not-equal** reads a register again and again until the masked read data differs from a target.

The polls have no timeout. An opcode outside the five is retired like a null and raises a sticky error flag.

Top module: `cmdq_exec`

## Requirements
- R1: After reset `busy`, `done`, `err` and `bus_req` are low and `cmd_ready` is high.
- R2: The opcode is word bits [63:60] (0 null, 1 write, 2 wait, 3 poll-equal, 4 poll-not-equal). A word is taken only while `cmd_ready` is high. `cmd_ready` is low and `busy` high from the cycle after a non-null command is taken until it retires.
- R3: A null command raises `done` for one cycle in the cycle after it is taken. It starts no bus access and leaves `busy` low.
- R4: A write command makes exactly one bus access with `bus_we` high. `bus_addr` is word bits [55:32], `bus_wdata` is bits [31:16] and `bus_wmask` (a per-bit write enable) is bits [15:0]. `done` pulses in the cycle after the access is acknowledged.
- R5: Once raised, `bus_req` stays high with `bus_addr` and `bus_we` unchanged until a cycle with `bus_ack` high.
- R6: A wait command selects trigger line word[3:0]. It does not retire while that line is low, whatever the other lines do. `done` pulses in the cycle after the line is seen high.
- R7: A poll-equal command reads `bus_addr` (bits [55:32]) with `bus_we` low. It re-issues the read until ((rdata XOR value) AND mask) is zero, where value is bits [31:16] and mask is bits [15:0]. `done` pulses after the acknowledge of the read that matches.
- R8: A poll-not-equal command reads the same way, and re-issues the read until ((rdata XOR value) AND mask) is non-zero.
- R9: Opcodes 5 to 15 retire like a null and set `err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Executor idle, word is taken this cycle |
| cmd_word | input | 64 | Command word |
| bus_req | output | 1 | Register-bus request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 24 | Register address |
| bus_wdata | output | 16 | Write data |
| bus_wmask | output | 16 | Per-bit write enable |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` on reads |
| bus_ack | input | 1 | Access complete |
| trig | input | 16 | Trigger event lines |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse per retired command |
| err | output | 1 | Sticky unknown-opcode flag |

## Verification
Every result is one register stage from its cause:
- a null or unknown opcode shows `done` (and `err`) in the first cycle after acceptance;
- a write retires one cycle after its acknowledge, so with an acknowledge latency of L idle cycles `done` appears L+1 cycles after acceptance;
- a wait retires one cycle after the selected line rises.

The bench drives on falling edges and samples on the following falling edge, exactly one register delay later. While the selected line is held low, it checks over several cycles that nothing retires. For polls it recomputes in the bench how many reads the masked compare needs against a stepping read-data model, and compares that with the number of reads the bus model served.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
package cmdq_pkg;
  localparam int WORD_W = 64;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int TRIG_N = 16;
  localparam int SEL_W  = $clog2(TRIG_N);
  localparam int OP_W   = 4;
  // field positions inside a command word
  localparam int OP_LSB   = WORD_W - OP_W;
  localparam int ADDR_LSB = 2 * DATA_W;
  localparam int VAL_LSB  = DATA_W;

  typedef enum logic [OP_W-1:0] {
    OP_NULL  = 4'd0,
    OP_WRITE = 4'd1,
    OP_WAIT  = 4'd2,
    OP_PEQ   = 4'd3,
    OP_PNE   = 4'd4
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_WAIT} st_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic              known;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] val;
    logic [DATA_W-1:0] mask;
    logic [SEL_W-1:0]  sel;
  } cmd_t;

  // true when the bits selected by m agree between a and b
  function automatic logic masked_same(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b,
                                       logic [DATA_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction
endpackage

// File: rtl/cmdq_decode.sv
`timescale 1ns/1ps
module cmdq_decode
  import cmdq_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output cmd_t              cmd
);
  logic unused_rsv;
  assign unused_rsv = ^word[OP_LSB-1:ADDR_LSB+ADDR_W];

  always_comb begin
    cmd.op    = word[WORD_W-1:OP_LSB];
    cmd.known = (word[WORD_W-1:OP_LSB] <= OP_PNE);
    cmd.addr  = word[ADDR_LSB +: ADDR_W];
    cmd.val   = word[VAL_LSB +: DATA_W];
    cmd.mask  = word[0 +: DATA_W];
    cmd.sel   = word[0 +: SEL_W];
  end
endmodule

// File: rtl/cmdq_cond.sv
`timescale 1ns/1ps
module cmdq_cond
  import cmdq_pkg::*;
(
  input  cmd_t              cmd,
  input  logic [DATA_W-1:0] rdata,
  input  logic [TRIG_N-1:0] trig,
  output logic              trig_hit,
  output logic              poll_ok
);
  logic same;
  assign same     = masked_same(rdata, cmd.val, cmd.mask);
  assign poll_ok  = (cmd.op == OP_PNE) ? !same : same;
  assign trig_hit = trig[cmd.sel];
endmodule

// File: rtl/cmdq_exec.sv
`timescale 1ns/1ps
module cmdq_exec
  import cmdq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_wmask,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic [TRIG_N-1:0] trig,
  output logic              busy,
  output logic              done,
  output logic              err
);
  st_e  st;
  cmd_t in_cmd, cur;
  logic trig_hit, poll_ok;

  cmdq_decode u_dec (.word(cmd_word), .cmd(in_cmd));
  cmdq_cond  u_cond (.cmd(cur), .rdata(bus_rdata), .trig(trig),
                     .trig_hit(trig_hit), .poll_ok(poll_ok));

  // named events for the checks
  logic take, bus_done, wait_done;
  assign take      = cmd_valid && cmd_ready;
  assign bus_done  = (st == ST_BUS) && bus_ack && (bus_we || poll_ok);
  assign wait_done = (st == ST_WAIT) && trig_hit;

  assign cmd_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign bus_req   = (st == ST_BUS);
  assign bus_we    = (cur.op == OP_WRITE);
  assign bus_addr  = cur.addr;
  assign bus_wdata = cur.val;
  assign bus_wmask = cur.mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cur  <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          cur <= in_cmd;
          case (in_cmd.op)
            OP_WRITE, OP_PEQ, OP_PNE: st <= ST_BUS;
            OP_WAIT:                  st <= ST_WAIT;
            default: begin
              done <= 1'b1;
              if (!in_cmd.known) err <= 1'b1;
            end
          endcase
        end
        ST_BUS: if (bus_done) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
        ST_WAIT: if (wait_done) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  null_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_word[WORD_W-1:OP_LSB] == OP_NULL |=> done && !busy && !bus_req);
  // R2
  write_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_word[WORD_W-1:OP_LSB] == OP_WRITE |=> busy && bus_req && !cmd_ready);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));
  // R4
  write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack && bus_we |=> done && !busy);
  // R6
  wait_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) && !trig_hit |=> !done && busy);
  // R7
  poll_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack && !bus_we && !poll_ok |=> bus_req && !done);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: tb/cmdq_exec_bench.sv
`timescale 1ns/1ps
module cmdq_exec_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [63:0] cmd_word = '0;
  logic        bus_req, bus_we, bus_ack = 1'b0;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata, bus_wmask, bus_rdata = '0;
  logic [15:0] trig = '0;
  logic        busy, done, err;

  cmdq_exec u_cmdq_exec (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_word(cmd_word), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wmask(bus_wmask),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .trig(trig), .busy(busy),
    .done(done), .err(err));

  int n_tests = 0, n_fail = 0;
  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus responder: acknowledges after lat idle cycles, read data steps per read
  int lat = 0, cnt = 0, nreads = 0, nwrites = 0;
  logic [15:0] rd_base = '0, rd_step = '0;
  logic [23:0] w_addr = '0, r_addr = '0;
  logic [15:0] w_data = '0, w_mask = '0;
  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      if (cnt >= lat) begin
        bus_ack = 1'b1;
        cnt = 0;
        if (bus_we) begin
          nwrites++; w_addr = bus_addr; w_data = bus_wdata; w_mask = bus_wmask;
        end else begin
          bus_rdata = rd_base + rd_step * 16'(nreads);
          nreads++; r_addr = bus_addr;
        end
      end else cnt++;
    end
  end

  function automatic logic [63:0] mk(logic [3:0] op, logic [23:0] a, logic [15:0] v,
                                     logic [15:0] m);
    return {op, 4'h0, a, v, m};
  endfunction

  task automatic send(logic [63:0] w);
    @(negedge clk); cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cyc, w0, r0;
    do_reset();
    // R1
    check(!busy && !done && !err && !bus_req && cmd_ready, "R1", "reset state",
          {busy, done, err, bus_req, cmd_ready}, 5'b00001);

    // R3 null
    w0 = nwrites; r0 = nreads;
    send(mk(4'h0, 24'hABCDEF, 16'h1234, 16'hFFFF));
    check(done && !busy && !bus_req, "R3", "null retire", {done, busy, bus_req}, 3'b100);
    @(negedge clk);
    check(!done && nwrites == w0 && nreads == r0 && !err, "R3", "null no bus/err",
          {done, err}, 2'b00);

    // R4 write sweep with varied ack latency
    for (int i = 0; i < 8; i++) begin
      logic [23:0] a; logic [15:0] d, m;
      a = 24'h010000 * 24'(i) + 24'h0000A5 + 24'(i * 7);
      d = 16'hA5C3 ^ 16'(i * 16'h1111);
      m = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : (16'h00FF << i);
      lat = i % 4; w0 = nwrites;
      send(mk(4'h1, a, d, m));
      check(busy && bus_req && bus_we && !cmd_ready, "R2", "write in progress",
            {busy, bus_req, bus_we, cmd_ready}, 4'b1110);
      wait_done(cyc);
      check(cyc == lat + 1, "R4", "write done latency", cyc, lat + 1);
      check(nwrites == w0 + 1, "R4", "one write access", nwrites - w0, 1);
      check(w_addr == a && w_data == d && w_mask == m, "R4", "write fields",
            {w_addr, w_data, w_mask}, {a, d, m});
      @(negedge clk);
      check(!busy && cmd_ready && !done, "R2", "idle after write",
            {busy, cmd_ready, done}, 3'b010);
    end

    // R6 wait on every trigger line
    for (int s = 0; s < 16; s++) begin
      trig = ~(16'h1 << s);
      send(mk(4'h2, 24'h0, 16'h0, 16'(s)));
      for (int k = 0; k < 3; k++) begin
        check(!done && busy, "R6", "wait holds with other lines high", {done, busy}, 2'b01);
        @(negedge clk);
      end
      trig = 16'h1 << s;
      @(negedge clk);
      check(done == 1'b1, "R6", "wait retires after line rises", done, 1);
      trig = '0;
      @(negedge clk);
      check(!busy, "R6", "idle after wait", busy, 0);
    end

    // R7 / R8 poll sweeps, expected read count computed here
    for (int pe = 0; pe < 2; pe++) begin
      for (int j = 0; j < 6; j++) begin
        logic [15:0] m, v; int k; bit hit;
        rd_base = 16'h0200; rd_step = 16'h1; lat = j % 3;
        m = 16'h003F ^ (16'h1 << j);
        v = (pe == 0) ? 16'(7 * j + 3) : rd_base;
        k = -1;
        for (int n = 0; n < 64 && k < 0; n++) begin
          logic [15:0] r;
          r = rd_base + 16'(n);
          hit = (((r ^ v) & m) == 0);
          if (pe == 1) hit = !hit;
          if (hit) k = n;
        end
        nreads = 0;
        send(mk((pe == 0) ? 4'h3 : 4'h4, 24'h00C000 + 24'(j), v, m));
        check(busy && bus_req && !bus_we, "R7", "poll reads", {busy, bus_req, bus_we}, 3'b110);
        wait_done(cyc);
        check(done == 1'b1, pe ? "R8" : "R7", "poll retires", done, 1);
        check(nreads == k + 1, pe ? "R8" : "R7", "poll read count", nreads, k + 1);
        check(r_addr == 24'h00C000 + 24'(j), pe ? "R8" : "R7", "poll address",
              r_addr, 24'h00C000 + 24'(j));
        @(negedge clk);
        check(!busy, pe ? "R8" : "R7", "idle after poll", busy, 0);
      end
    end

    // R9 unknown opcodes
    for (int op = 5; op < 16; op++) begin
      w0 = nwrites; r0 = nreads;
      send(mk(4'(op), 24'h123456, 16'hFFFF, 16'hFFFF));
      check(done && err && !busy, "R9", "unknown retires and flags",
            {done, err, busy}, 3'b110);
      @(negedge clk);
      check(nwrites == w0 && nreads == r0, "R9", "unknown no bus", nwrites - w0, 0);
    end
    lat = 0;
    send(mk(4'h1, 24'h7, 16'h1, 16'h1));
    wait_done(cyc);
    check(err == 1'b1, "R9", "err sticky across valid command", err, 1);
    do_reset();
    check(err == 1'b0 && cmd_ready, "R9", "err cleared by reset", err, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule